// File: doc/BRIEF.md
# Eight-Channel Serial Port Host Register Front End

This block sits between a host processor bus and eight 16550-style serial channel cores. The host sees one chip select, an 8-bit address, an 8-bit data bus and separate active-low read and write strobes. The front end turns each access into either a channel register access, a broadcast write that reaches all channels together, or an access to a small set of device-wide registers held inside the block.

The address map is flat. Address bit 7 low means channel space: bits 6:4 pick the channel and bits 3:0 pick the register offset inside that channel. Address bit 7 high means device space. There, bit 6 high opens a broadcast window whose low four bits are the channel register offset, and bit 6 low reaches the device registers: a per-channel reset pulse register, a per-channel sleep register, a per-channel sampling-rate register and two read-only identity constants. Extended channel registers at offsets 8 to 15 need no unlock sequence. Only offsets 0 and 1 are diverted to the divisor latch, and only when that channel reports its divisor-latch-enable bit set.

Read data is combinational while chip select and the read strobe are both low. Writes take effect on the rising clock edge while chip select and the write strobe are both low.

Top module: `uart_hostfront`

## Requirements
- R1: With cs_n and rd_n low and addr[7]=0, exactly the chan_sel bit numbered addr[6:4] is high, chan_reg equals addr[3:0], and rdata equals the chan_rdata byte of that channel (bits 8*n+7 down to 8*n for channel n).
- R2: With cs_n and wr_n low and addr[7]=0, chan_we has only the bit numbered addr[6:4] set, and chan_wdata equals wdata.
- R3: While cs_n is high, or while cs_n is low with both strobes high, chan_sel and chan_we are all zero and rdata is 0x00. A write strobe with cs_n high changes no device register.
- R4: Offsets 2 to 15 in channel space, including extended offsets 8 to 15, are reached directly: chan_dl_acc stays all zero for them whatever chan_dlab holds.
- R5: For offsets 0 and 1, chan_dl_acc bit n is high exactly when channel n is the target of the access and chan_dlab bit n is high.
- R6: A write to addresses 0xC0 to 0xCF sets every chan_we bit, drives chan_reg with addr[3:0], and sets chan_dl_acc bit n for offsets 0 and 1 when chan_dlab bit n is high. A read in that window returns 0x00 with chan_sel all zero.
- R7: A write to 0x80 loads ch_srst with wdata on that clock edge; each bit is cleared on the following edge unless 0x80 is written again in that cycle, in which case ch_srst takes the new data.
- R8: Address 0x81 is a read/write register driving ch_sleep; bit n high puts channel n to sleep.
- R9: Address 0x82 is a read/write register driving ch_samp8x; bit n high selects the 8x sampling clock for channel n, low selects 16x.
- R10: Address 0x83 reads the revision constant (default 0x03) and 0x84 reads the identity constant (default 0x5C); writes to them have no effect.
- R11: Reads of device addresses 0x85 to 0xBF return 0x00, and writes to them leave ch_sleep and ch_samp8x unchanged.
- R12: After reset ch_srst, ch_sleep and ch_samp8x are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select for the whole device |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 8 | Flat register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during a read |
| chan_sel | output | 8 | One-hot select of the addressed channel |
| chan_we | output | 8 | Per-channel write enable, all set on broadcast |
| chan_reg | output | 4 | Register offset inside the channel |
| chan_wdata | output | 8 | Write data forwarded to the channels |
| chan_dl_acc | output | 8 | Per-channel flag: access goes to the divisor latch |
| chan_dlab | input | 8 | Divisor-latch-enable bit reported by each channel |
| chan_rdata | input | 64 | Read bytes from all channels, channel n in bits 8n+7:8n |
| ch_srst | output | 8 | One-cycle software reset pulses per channel |
| ch_sleep | output | 8 | Sleep control per channel |
| ch_samp8x | output | 8 | 8x sampling select per channel |

## Verification
The software reset register is the one place where two functions meet in one cycle: the self-clear of a pulse already loaded and a fresh write to the same register. The bench writes 0x80 on two back-to-back edges with different data and expects the second value to replace the first without a zero cycle in between, then a clear on the edge after. A broadcast write to a divisor offset also joins the all-channel write with the per-channel divisor gating in a single access, judged by comparing chan_we and chan_dl_acc against the chan_dlab pattern driven.

// File: rtl/uart_hostfront_pkg.sv
package uart_hostfront_pkg;

  localparam int CH_IDX_W = 3;
  localparam int REG_OFF_W = 4;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_CHAN  = 2'd1,
    RG_DEV   = 2'd2,
    RG_BCAST = 2'd3
  } region_e;

  localparam logic [6:0] DEV_SRST  = 7'h00;
  localparam logic [6:0] DEV_SLEEP = 7'h01;
  localparam logic [6:0] DEV_SAMP  = 7'h02;
  localparam logic [6:0] DEV_REV   = 7'h03;
  localparam logic [6:0] DEV_ID    = 7'h04;

endpackage

// File: rtl/uart_hostfront_decode.sv
module uart_hostfront_decode
  import uart_hostfront_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [7:0]           addr,
  input  logic [NCH-1:0]       dlab,
  output region_e              region,
  output logic [CH_IDX_W-1:0]  ch,
  output logic [REG_OFF_W-1:0] off,
  output logic                 rd_act,
  output logic [NCH-1:0]       sel,
  output logic [NCH-1:0]       we,
  output logic [NCH-1:0]       dl_acc,
  output logic                 wr_srst,
  output logic                 wr_sleep,
  output logic                 wr_samp
);

  logic       wr_act;
  logic       any_act;
  logic       dl_off;
  logic [6:0] dev_off;

  always_comb begin
    rd_act  = !cs_n && !rd_n;
    wr_act  = !cs_n && !wr_n;
    any_act = rd_act || wr_act;
    ch      = addr[6:4];
    off     = addr[3:0];
    dev_off = addr[6:0];
    dl_off  = (addr[3:1] == 3'b000);
    if (!any_act)        region = RG_NONE;
    else if (!addr[7])   region = RG_CHAN;
    else if (addr[6])    region = RG_BCAST;
    else                 region = RG_DEV;
    wr_srst  = wr_act && (region == RG_DEV) && (dev_off == DEV_SRST);
    wr_sleep = wr_act && (region == RG_DEV) && (dev_off == DEV_SLEEP);
    wr_samp  = wr_act && (region == RG_DEV) && (dev_off == DEV_SAMP);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    logic hit;
    logic tgt;
    always_comb begin
      hit       = (region == RG_CHAN) && (ch == CH_IDX_W'(i));
      tgt       = hit || (wr_act && (region == RG_BCAST));
      sel[i]    = hit;
      we[i]     = wr_act && tgt;
      dl_acc[i] = tgt && dl_off && dlab[i];
    end
  end

endmodule

// File: rtl/uart_hostfront_devregs.sv
module uart_hostfront_devregs
  import uart_hostfront_pkg::*;
#(
  parameter int         NCH   = 8,
  parameter int         DW    = 8,
  parameter logic [7:0] REV   = 8'h03,
  parameter logic [7:0] DEVID = 8'h5C
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  wdata,
  input  logic [6:0]     dev_off,
  input  logic           wr_srst,
  input  logic           wr_sleep,
  input  logic           wr_samp,
  output logic [NCH-1:0] srst,
  output logic [NCH-1:0] sleep,
  output logic [NCH-1:0] samp8x,
  output logic [DW-1:0]  dev_rdata
);

  logic [NCH-1:0] srst_d;
  logic [NCH-1:0] sleep_d;
  logic [NCH-1:0] samp_d;
  logic           sleep_en;
  logic           samp_en;

  always_comb begin
    srst_d   = wr_srst ? wdata[NCH-1:0] : '0;
    sleep_en = wr_sleep;
    sleep_d  = wdata[NCH-1:0];
    samp_en  = wr_samp;
    samp_d   = wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst <= '0;
    end else begin
      srst <= srst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep <= '0;
    end else if (sleep_en) begin
      sleep <= sleep_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp8x <= '0;
    end else if (samp_en) begin
      samp8x <= samp_d;
    end
  end

  always_comb begin
    dev_rdata = '0;
    case (dev_off)
      DEV_SRST:  dev_rdata[NCH-1:0] = srst;
      DEV_SLEEP: dev_rdata[NCH-1:0] = sleep;
      DEV_SAMP:  dev_rdata[NCH-1:0] = samp8x;
      DEV_REV:   dev_rdata = DW'(REV);
      DEV_ID:    dev_rdata = DW'(DEVID);
      default:   dev_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_hostfront_rdmux.sv
module uart_hostfront_rdmux
  import uart_hostfront_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  region_e             region,
  input  logic [CH_IDX_W-1:0] ch,
  input  logic                rd_act,
  input  logic [NCH*DW-1:0]   chan_rdata,
  input  logic [DW-1:0]       dev_rdata,
  output logic [DW-1:0]       rdata
);

  logic [DW-1:0] lane [NCH];
  logic [DW-1:0] chan_pick;

  for (genvar i = 0; i < NCH; i++) begin : g_unpack
    assign lane[i] = chan_rdata[i*DW +: DW];
  end

  always_comb begin
    chan_pick = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch == CH_IDX_W'(i)) chan_pick = lane[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_act) begin
      case (region)
        RG_CHAN: rdata = chan_pick;
        RG_DEV:  rdata = dev_rdata;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_hostfront.sv
module uart_hostfront
  import uart_hostfront_pkg::*;
#(
  parameter int         NCH   = 8,
  parameter int         DW    = 8,
  parameter logic [7:0] REV   = 8'h03,
  parameter logic [7:0] DEVID = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [7:0]           addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [NCH-1:0]       chan_sel,
  output logic [NCH-1:0]       chan_we,
  output logic [REG_OFF_W-1:0] chan_reg,
  output logic [DW-1:0]        chan_wdata,
  output logic [NCH-1:0]       chan_dl_acc,
  input  logic [NCH-1:0]       chan_dlab,
  input  logic [NCH*DW-1:0]    chan_rdata,
  output logic [NCH-1:0]       ch_srst,
  output logic [NCH-1:0]       ch_sleep,
  output logic [NCH-1:0]       ch_samp8x
);

  logic [1:0]          rst_sync;
  logic                rst_int_n;
  region_e             region;
  logic [CH_IDX_W-1:0] ch;
  logic                rd_act;
  logic                wr_srst;
  logic                wr_sleep;
  logic                wr_samp;
  logic [DW-1:0]       dev_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  assign chan_wdata = wdata;

  uart_hostfront_decode #(.NCH(NCH)) u_dec (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .dlab     (chan_dlab),
    .region   (region),
    .ch       (ch),
    .off      (chan_reg),
    .rd_act   (rd_act),
    .sel      (chan_sel),
    .we       (chan_we),
    .dl_acc   (chan_dl_acc),
    .wr_srst  (wr_srst),
    .wr_sleep (wr_sleep),
    .wr_samp  (wr_samp)
  );

  uart_hostfront_devregs #(.NCH(NCH), .DW(DW), .REV(REV), .DEVID(DEVID)) u_dev (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wdata     (wdata),
    .dev_off   (addr[6:0]),
    .wr_srst   (wr_srst),
    .wr_sleep  (wr_sleep),
    .wr_samp   (wr_samp),
    .srst      (ch_srst),
    .sleep     (ch_sleep),
    .samp8x    (ch_samp8x),
    .dev_rdata (dev_rdata)
  );

  uart_hostfront_rdmux #(.NCH(NCH), .DW(DW)) u_rd (
    .region     (region),
    .ch         (ch),
    .rd_act     (rd_act),
    .chan_rdata (chan_rdata),
    .dev_rdata  (dev_rdata),
    .rdata      (rdata)
  );

endmodule

// File: rtl/uart_hostfront_chk.sv
module uart_hostfront_chk #(
  parameter int         NCH = 8,
  parameter int         DW  = 8,
  parameter logic [7:0] REV = 8'h03
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           rd_n,
  input logic           wr_n,
  input logic [7:0]     addr,
  input logic [DW-1:0]  rdata,
  input logic [NCH-1:0] chan_sel,
  input logic [NCH-1:0] chan_we,
  input logic [NCH-1:0] chan_dl_acc,
  input logic [NCH-1:0] ch_srst,
  input logic [NCH-1:0] ch_sleep
);

  logic bus_wr;
  logic bus_rd;
  assign bus_wr = !cs_n && !wr_n;
  assign bus_rd = !cs_n && !rd_n;

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel));

  // R3
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (chan_sel == '0 && chan_we == '0 && rdata == '0));

  // R4
  enh_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr[7] && addr[3:1] != 3'b000) |-> (chan_dl_acc == '0));

  // R6
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr[7:6] == 2'b11) |-> (&chan_we));

  // R7
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_srst != '0 && !(bus_wr && addr == 8'h80)) |=> (ch_srst == '0));

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && addr == 8'h81) |=> $stable(ch_sleep));

  // R10
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && addr == 8'h83) |-> (rdata == DW'(REV)));

endmodule

bind uart_hostfront uart_hostfront_chk #(.NCH(NCH), .DW(DW), .REV(REV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .addr        (addr),
  .rdata       (rdata),
  .chan_sel    (chan_sel),
  .chan_we     (chan_we),
  .chan_dl_acc (chan_dl_acc),
  .ch_srst     (ch_srst),
  .ch_sleep    (ch_sleep)
);

// File: tb/uart_hostfront_test.sv
module uart_hostfront_test;

  localparam int NCH = 8;
  localparam int DW  = 8;

  logic            clk;
  logic            rst_n;
  logic            cs_n, rd_n, wr_n;
  logic [7:0]      addr;
  logic [7:0]      wdata;
  logic [7:0]      rdata;
  logic [7:0]      chan_sel, chan_we, chan_dl_acc, chan_dlab;
  logic [3:0]      chan_reg;
  logic [7:0]      chan_wdata;
  logic [63:0]     chan_rdata;
  logic [7:0]      ch_srst, ch_sleep, ch_samp8x;

  int total = 0;
  int bad = 0;
  bit done = 0;

  uart_hostfront uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .chan_sel(chan_sel),
    .chan_we(chan_we), .chan_reg(chan_reg), .chan_wdata(chan_wdata),
    .chan_dl_acc(chan_dl_acc), .chan_dlab(chan_dlab), .chan_rdata(chan_rdata),
    .ch_srst(ch_srst), .ch_sleep(ch_sleep), .ch_samp8x(ch_samp8x)
  );

  // channel stubs: each returns a byte built from its number and the offset
  for (genvar i = 0; i < NCH; i++) begin : g_stub
    assign chan_rdata[i*8 +: 8] = {1'b0, 3'(i), chan_reg} ^ 8'hA0;
  end

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] stub_byte(input logic [7:0] a);
    return {1'b0, a[6:0]} ^ 8'hA0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    idle();
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #5;
    d = rdata;
    @(negedge clk);
    idle();
  endtask

  // {addr, dlab, expected chan_sel, expected chan_dl_acc}
  localparam int NVEC = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h01, 8'h00},
    {8'h01, 8'h01, 8'h01, 8'h01},
    {8'h10, 8'h02, 8'h02, 8'h02},
    {8'h15, 8'hFF, 8'h02, 8'h00},
    {8'h38, 8'hFF, 8'h08, 8'h00},
    {8'h4F, 8'h00, 8'h10, 8'h00},
    {8'h70, 8'h80, 8'h80, 8'h80},
    {8'h71, 8'h7F, 8'h80, 8'h00},
    {8'h6C, 8'h40, 8'h40, 8'h00},
    {8'h20, 8'h04, 8'h04, 8'h04}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    idle();
    addr = '0; wdata = '0; chan_dlab = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 srst", 32'(ch_srst), 32'h0);
    chk("R12 sleep", 32'(ch_sleep), 32'h0);
    chk("R12 samp", 32'(ch_samp8x), 32'h0);

    // R3 no strobes
    @(negedge clk);
    addr = 8'h12; cs_n = 1'b0;
    #5;
    chk("R3 sel idle", 32'(chan_sel), 32'h0);
    chk("R3 rdata idle", 32'(rdata), 32'h0);
    idle();

    // R1 R4 R5 vector table of channel reads
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      addr = VEC[k][31:24]; chan_dlab = VEC[k][23:16];
      cs_n = 1'b0; rd_n = 1'b0;
      #5;
      chk("R1 sel", 32'(chan_sel), 32'(VEC[k][15:8]));
      chk("R1 reg", 32'(chan_reg), 32'(VEC[k][27:24]));
      chk("R1 rdata", 32'(rdata), 32'(stub_byte(VEC[k][31:24])));
      chk("R5 R4 dl_acc", 32'(chan_dl_acc), 32'(VEC[k][7:0]));
      chk("R1 no we on read", 32'(chan_we), 32'h0);
      idle();
    end

    // R2 single channel write
    @(negedge clk);
    addr = 8'h35; wdata = 8'h5A; chan_dlab = 8'hFF; cs_n = 1'b0; wr_n = 1'b0;
    #5;
    chk("R2 we", 32'(chan_we), 32'h08);
    chk("R2 wdata", 32'(chan_wdata), 32'h5A);
    chk("R2 reg", 32'(chan_reg), 32'h5);
    idle();

    // R6 broadcast writes
    @(negedge clk);
    addr = 8'hC3; wdata = 8'h11; chan_dlab = 8'hF0; cs_n = 1'b0; wr_n = 1'b0;
    #5;
    chk("R6 we all", 32'(chan_we), 32'hFF);
    chk("R6 reg", 32'(chan_reg), 32'h3);
    chk("R6 no dl off3", 32'(chan_dl_acc), 32'h0);
    addr = 8'hC1; chan_dlab = 8'h0F;
    #2;
    chk("R6 dl per chan", 32'(chan_dl_acc), 32'h0F);
    idle();
    @(negedge clk);
    addr = 8'hC2; cs_n = 1'b0; rd_n = 1'b0;
    #5;
    chk("R6 bcast read data", 32'(rdata), 32'h0);
    chk("R6 bcast read sel", 32'(chan_sel), 32'h0);
    idle();

    // R8 R9
    bus_write(8'h81, 8'hA5);
    chk("R8 sleep out", 32'(ch_sleep), 32'hA5);
    bus_read(8'h81, rd);
    chk("R8 sleep read", 32'(rd), 32'hA5);
    bus_write(8'h82, 8'h3C);
    chk("R9 samp out", 32'(ch_samp8x), 32'h3C);
    bus_read(8'h82, rd);
    chk("R9 samp read", 32'(rd), 32'h3C);

    // R3 write with cs_n high ignored
    @(negedge clk);
    addr = 8'h81; wdata = 8'h00; cs_n = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    idle();
    chk("R3 cs high no write", 32'(ch_sleep), 32'hA5);

    // R10 constants, writes ignored
    bus_write(8'h83, 8'hFF);
    bus_write(8'h84, 8'h00);
    bus_read(8'h83, rd);
    chk("R10 rev", 32'(rd), 32'h03);
    bus_read(8'h84, rd);
    chk("R10 id", 32'(rd), 32'h5C);

    // R11 unimplemented device addresses
    bus_write(8'h90, 8'h77);
    bus_write(8'hBF, 8'h00);
    bus_read(8'h90, rd);
    chk("R11 read zero", 32'(rd), 32'h0);
    bus_read(8'h85, rd);
    chk("R11 read zero 85", 32'(rd), 32'h0);
    chk("R11 sleep kept", 32'(ch_sleep), 32'hA5);
    chk("R11 samp kept", 32'(ch_samp8x), 32'h3C);

    // R7 single pulse
    bus_write(8'h80, 8'h81);
    chk("R7 pulse set", 32'(ch_srst), 32'h81);
    @(negedge clk);
    chk("R7 pulse clear", 32'(ch_srst), 32'h0);

    // R7 back-to-back writes: second replaces first, then clears
    @(negedge clk);
    addr = 8'h80; wdata = 8'h01; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    chk("R7 first", 32'(ch_srst), 32'h01);
    wdata = 8'h02;
    @(negedge clk);
    idle();
    chk("R7 second", 32'(ch_srst), 32'h02);
    @(negedge clk);
    chk("R7 final clear", 32'(ch_srst), 32'h0);
    chk("R7 sleep untouched", 32'(ch_sleep), 32'hA5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule